// File: doc/BRIEF.md
# Legacy I/O Combo Configuration Port

This block is the configuration front end of a multi-function legacy I/O device. Software reaches it through two adjacent byte addresses. One is an index port that picks one of three 8-bit configuration registers. The other is a data port that reads or writes the register the index points at. The three registers hold a function-enable byte, a function-address byte and a power/test byte. The block decodes them into enable flags, I/O base addresses and interrupt numbers for one parallel port, two serial ports, a floppy controller and an IDE channel. The peripherals themselves consume these outputs.

After every reset, the first two reads of the index port return a fixed identification pair. Only after that does the index port return the current index. The power-up register contents come from built-in tables indexed by a 5-bit board strap. Boards normally tie the strap to 1. The decoded outputs are registered. Each change of a configuration register is announced by a single-cycle reconfiguration pulse, so that downstream logic can re-map its ports.

Top module: `sio_cfg_port`

## Requirements
- R1: `busSel` = 0 addresses the index port and `busSel` = 1 addresses the data port. Once the identification pair has been read, or after any index write, an index-port read returns the last byte written to the index port.
- R2: A data-port write while the index is 0 (enable byte), 1 (address byte) or 2 (power/test byte) stores the byte in that register, and a data-port read returns it.
- R3: While the index is 3 or higher, data-port writes change no register and no decoded output, and data-port reads return 0x00.
- R4: After reset, the first index-port read returns 0x88 and the second returns 0x00. Every later index-port read returns the index.
- R5: An index-port write ends the identification pair at once, so the next index-port read returns the new index.
- R6: Reset (synchronous, `rstN` low) sets the index to 0 and loads the three registers from strap-indexed tables. Some of the table entries:
  - strap 1 gives enable 0x4F, address 0x11 and power/test 0x00.
  - strap 6 gives enable 0x4B and address 0x00.
  - strap 31 gives enable 0x00, address 0x10 and power/test 0x02.
- R7: Parallel port:
  - It is enabled by enable bit 0, and address bits 1:0 select its base: 0 gives 0x378, 1 gives 0x3BC, 2 gives 0x278 and 3 gives none (base 0).
  - For select 0, the IRQ is 7 if power/test bit 3 is set and 5 otherwise. Select 1 gives IRQ 7, select 2 gives IRQ 5 and select 3 gives IRQ 0.
- R8: Serial ports:
  - Serial port n (n = 0, 1) is enabled by enable bit 1+n. Its 2-bit select is address bits 2n+3:2n+2.
  - Select 0 gives base 0x3F8 and select 1 gives base 0x2F8.
  - For select 2, address bits 7:6 = 0..3 pick 0x3E8, 0x338, 0x2E8 or 0x220. For select 3 they pick 0x2E8, 0x238, 0x2E0 or 0x228.
  - The IRQ is 3 for an odd select and 4 for an even select.
- R9: The floppy controller is enabled by enable bit 3. Its base is 0x370 when enable bit 5 is set and 0x3F0 otherwise, and its IRQ is 6.
- R10: IDE:
  - It is enabled by enable bit 6. Its primary base is 0x170 when enable bit 7 is set and 0x1F0 otherwise.
  - The auxiliary base is the primary base plus 0x206, and the IRQ is 14.
- R11: Timing of decoded outputs and the reconfiguration pulse:
  - A data write captured at clock edge k shows on the decoded outputs after edge k+1.
  - `reconfig` is high for exactly the cycle after edge k+1, and only if the write changed the register's value.
  - Writing a register's current value produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strap | input | 5 | Board strap selecting reset contents |
| busSel | input | 1 | Address bit 0: 0 index port, 1 data port |
| wrEn | input | 1 | Byte write strobe |
| rdEn | input | 1 | Byte read strobe (advances identification pair) |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte for the addressed port |
| parEn | output | 1 | Parallel port enable |
| parBase | output | 16 | Parallel port base |
| parIrq | output | 4 | Parallel port IRQ |
| uart0En | output | 1 | Serial port 0 enable |
| uart0Base | output | 16 | Serial port 0 base |
| uart0Irq | output | 4 | Serial port 0 IRQ |
| uart1En | output | 1 | Serial port 1 enable |
| uart1Base | output | 16 | Serial port 1 base |
| uart1Irq | output | 4 | Serial port 1 IRQ |
| fdcEn | output | 1 | Floppy controller enable |
| fdcBase | output | 16 | Floppy controller base |
| fdcIrq | output | 4 | Floppy controller IRQ |
| ideEn | output | 1 | IDE enable |
| ideBase | output | 16 | IDE primary base |
| ideAuxBase | output | 16 | IDE auxiliary base |
| ideIrq | output | 4 | IDE IRQ |
| reconfig | output | 1 | One-cycle pulse after a register value changes |

## Verification
The bench targets the identification pair. A design that skipped it, or ran it one read too long, would return the index too early or 0x88 where the index belongs. An index write halfway through the pair must end it at once; otherwise 0x00 would come back instead of the new index. The bench writes the data port while the index is out of range. A design that wrapped the index onto the three registers would corrupt one of them and pulse `reconfig`. The bench also covers the parallel IRQ that depends on the power/test byte, the alternate serial tables for selects 2 and 3, strap-selected reset contents, and the exact cycle of the decoded update and its pulse. A design that reacted to same-value writes would raise spurious pulses.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int DATA_W   = 8;
  localparam int BASE_W   = 16;
  localparam int IRQ_W    = 4;
  localparam int STRAP_W  = 5;
  localparam int NUM_REG  = 3;
  localparam int NUM_UART = 2;

  typedef logic [DATA_W-1:0] cfg_byte_t;
  typedef logic [BASE_W-1:0] io_base_t;
  typedef logic [IRQ_W-1:0]  irq_num_t;

  localparam cfg_byte_t ID_BYTE_FIRST  = 8'h88;
  localparam cfg_byte_t ID_BYTE_SECOND = 8'h00;
  localparam io_base_t  IDE_AUX_OFS    = 16'h0206;

  typedef enum logic [1:0] {
    ID_FIRST  = 2'd0,
    ID_SECOND = 2'd1,
    ID_DONE   = 2'd2
  } id_phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic               idxWr;
    logic [NUM_REG-1:0] regWr;
    logic               idxRd;
  } cfg_strobe_t;

  // One decoded function
  typedef struct packed {
    logic     en;
    io_base_t base;
    irq_num_t irq;
  } func_map_t;

  function automatic cfg_byte_t resetEnable(input logic [STRAP_W-1:0] s);
    cfg_byte_t v;
    if (s <= 5'd5)       v = 8'h4F;
    else if (s <= 5'd11) v = 8'h4B;
    else if (s <= 5'd15) v = 8'h0F;
    else if (s <= 5'd19) v = 8'h49;
    else if (s <= 5'd23) v = 8'h07;
    else if (s <= 5'd29) v = 8'h47;
    else if (s == 5'd30) v = 8'h08;
    else                 v = 8'h00;
    return v;
  endfunction

  function automatic cfg_byte_t resetAddress(input logic [STRAP_W-1:0] s);
    cfg_byte_t v;
    case (s)
      5'd0, 5'd12, 5'd20, 5'd24, 5'd30, 5'd31: v = 8'h10;
      5'd1, 5'd2, 5'd13, 5'd17, 5'd18, 5'd21,
      5'd25, 5'd26, 5'd7, 5'd8:                v = 8'h11;
      5'd3, 5'd14, 5'd22, 5'd27:               v = 8'h39;
      5'd4, 5'd15, 5'd23, 5'd28:               v = 8'h24;
      5'd5, 5'd29:                             v = 8'h38;
      5'd9:                                    v = 8'h09;
      5'd10, 5'd11:                            v = 8'h08;
      default:                                 v = 8'h00;
    endcase
    // entries 7, 8, 17, 18 hold 0x01 rather than 0x11
    if (s == 5'd7 || s == 5'd8 || s == 5'd17 || s == 5'd18) v = 8'h01;
    return v;
  endfunction

  function automatic cfg_byte_t resetPower(input logic [STRAP_W-1:0] s);
    return (s == 5'd31) ? 8'h02 : 8'h00;
  endfunction

  function automatic func_map_t parallelMap(input cfg_byte_t en, input cfg_byte_t ad,
                                            input cfg_byte_t pw);
    func_map_t m;
    m.en = en[0];
    case (ad[1:0])
      2'd0:    begin m.base = 16'h0378; m.irq = pw[3] ? 4'd7 : 4'd5; end
      2'd1:    begin m.base = 16'h03BC; m.irq = 4'd7; end
      2'd2:    begin m.base = 16'h0278; m.irq = 4'd5; end
      default: begin m.base = 16'h0000; m.irq = 4'd0; end
    endcase
    return m;
  endfunction

  function automatic io_base_t uartAltBase(input logic odd, input logic [1:0] pick);
    io_base_t b;
    if (!odd) begin
      case (pick)
        2'd0: b = 16'h03E8;
        2'd1: b = 16'h0338;
        2'd2: b = 16'h02E8;
        default: b = 16'h0220;
      endcase
    end else begin
      case (pick)
        2'd0: b = 16'h02E8;
        2'd1: b = 16'h0238;
        2'd2: b = 16'h02E0;
        default: b = 16'h0228;
      endcase
    end
    return b;
  endfunction

  function automatic func_map_t uartMap(input cfg_byte_t en, input cfg_byte_t ad,
                                        input int n);
    func_map_t  m;
    logic [1:0] sel;
    sel  = ad[2*n+2 +: 2];
    m.en = en[1+n];
    case (sel)
      2'd0:    m.base = 16'h03F8;
      2'd1:    m.base = 16'h02F8;
      default: m.base = uartAltBase(sel[0], ad[7:6]);
    endcase
    m.irq = sel[0] ? 4'd3 : 4'd4;
    return m;
  endfunction

  function automatic func_map_t floppyMap(input cfg_byte_t en);
    func_map_t m;
    m.en   = en[3];
    m.base = en[5] ? 16'h0370 : 16'h03F0;
    m.irq  = 4'd6;
    return m;
  endfunction

  function automatic func_map_t ideMap(input cfg_byte_t en);
    func_map_t m;
    m.en   = en[6];
    m.base = en[7] ? 16'h0170 : 16'h01F0;
    m.irq  = 4'd14;
    return m;
  endfunction

endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        wrEn,
  input  logic        rdEn,
  input  cfg_byte_t   curIdx,
  output cfg_strobe_t strobe,
  output id_phase_t   idPhase
);

  logic [NUM_REG-1:0] regWrVec;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg_sel
    assign regWrVec[r] = wrEn & busSel & (curIdx == cfg_byte_t'(r));
  end

  always_comb begin
    strobe.idxWr = wrEn & ~busSel;
    strobe.regWr = regWrVec;
    // a write in the same cycle takes precedence over a read
    strobe.idxRd = rdEn & ~wrEn & ~busSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idPhase <= ID_FIRST;
    end else if (strobe.idxWr) begin
      idPhase <= ID_DONE;
    end else if (strobe.idxRd) begin
      case (idPhase)
        ID_FIRST:  idPhase <= ID_SECOND;
        ID_SECOND: idPhase <= ID_DONE;
        default:   idPhase <= ID_DONE;
      endcase
    end
  end

endmodule

// File: rtl/sio_cfg_dp.sv
module sio_cfg_dp
  import sio_cfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [STRAP_W-1:0]   strap,
  input  cfg_strobe_t          strobe,
  input  id_phase_t            idPhase,
  input  logic                 busSel,
  input  cfg_byte_t            wrData,
  output cfg_byte_t            curIdx,
  output cfg_byte_t            rdData,
  output func_map_t            parMap,
  output func_map_t            uartMaps [NUM_UART],
  output func_map_t            fdcMap,
  output func_map_t            ideMap_o,
  output io_base_t             ideAux,
  output logic                 reconfig
);

  cfg_byte_t cfgReg [NUM_REG];
  cfg_byte_t idxReg;
  logic      regChanged;

  cfg_byte_t rstEnable, rstAddress, rstPower;
  assign rstEnable  = resetEnable(strap);
  assign rstAddress = resetAddress(strap);
  assign rstPower   = resetPower(strap);

  // configuration registers and index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg     <= '0;
      cfgReg[0]  <= rstEnable;
      cfgReg[1]  <= rstAddress;
      cfgReg[2]  <= rstPower;
      regChanged <= 1'b0;
    end else begin
      regChanged <= 1'b0;
      if (strobe.idxWr) idxReg <= wrData;
      for (int i = 0; i < NUM_REG; i++) begin
        if (strobe.regWr[i]) begin
          cfgReg[i] <= wrData;
          if (cfgReg[i] != wrData) regChanged <= 1'b1;
        end
      end
    end
  end

  // registered decode of the shared functions
  always_ff @(posedge clk) begin
    if (!rstN) begin
      parMap   <= parallelMap(rstEnable, rstAddress, rstPower);
      fdcMap   <= floppyMap(rstEnable);
      ideMap_o <= ideMap(rstEnable);
      reconfig <= 1'b0;
    end else begin
      parMap   <= parallelMap(cfgReg[0], cfgReg[1], cfgReg[2]);
      fdcMap   <= floppyMap(cfgReg[0]);
      ideMap_o <= ideMap(cfgReg[0]);
      reconfig <= regChanged;
    end
  end

  // one decoder per serial port
  for (genvar u = 0; u < NUM_UART; u++) begin : g_uart
    always_ff @(posedge clk) begin
      if (!rstN) uartMaps[u] <= uartMap(rstEnable, rstAddress, u);
      else       uartMaps[u] <= uartMap(cfgReg[0], cfgReg[1], u);
    end
  end

  assign ideAux = ideMap_o.base + IDE_AUX_OFS;
  assign curIdx = idxReg;

  always_comb begin
    if (busSel) begin
      case (idxReg)
        8'd0:    rdData = cfgReg[0];
        8'd1:    rdData = cfgReg[1];
        8'd2:    rdData = cfgReg[2];
        default: rdData = '0;
      endcase
    end else begin
      case (idPhase)
        ID_FIRST:  rdData = ID_BYTE_FIRST;
        ID_SECOND: rdData = ID_BYTE_SECOND;
        default:   rdData = idxReg;
      endcase
    end
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  strap,
  input  logic        busSel,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        parEn,
  output logic [15:0] parBase,
  output logic [3:0]  parIrq,
  output logic        uart0En,
  output logic [15:0] uart0Base,
  output logic [3:0]  uart0Irq,
  output logic        uart1En,
  output logic [15:0] uart1Base,
  output logic [3:0]  uart1Irq,
  output logic        fdcEn,
  output logic [15:0] fdcBase,
  output logic [3:0]  fdcIrq,
  output logic        ideEn,
  output logic [15:0] ideBase,
  output logic [15:0] ideAuxBase,
  output logic [3:0]  ideIrq,
  output logic        reconfig
);

  cfg_strobe_t strobe;
  id_phase_t   idPhase;
  cfg_byte_t   curIdx;
  func_map_t   parMap, fdcMap, ideMapQ;
  func_map_t   uartMaps [NUM_UART];

  sio_cfg_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .curIdx  (curIdx),
    .strobe  (strobe),
    .idPhase (idPhase)
  );

  sio_cfg_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strap    (strap),
    .strobe   (strobe),
    .idPhase  (idPhase),
    .busSel   (busSel),
    .wrData   (wrData),
    .curIdx   (curIdx),
    .rdData   (rdData),
    .parMap   (parMap),
    .uartMaps (uartMaps),
    .fdcMap   (fdcMap),
    .ideMap_o (ideMapQ),
    .ideAux   (ideAuxBase),
    .reconfig (reconfig)
  );

  assign parEn     = parMap.en;
  assign parBase   = parMap.base;
  assign parIrq    = parMap.irq;
  assign uart0En   = uartMaps[0].en;
  assign uart0Base = uartMaps[0].base;
  assign uart0Irq  = uartMaps[0].irq;
  assign uart1En   = uartMaps[1].en;
  assign uart1Base = uartMaps[1].base;
  assign uart1Irq  = uartMaps[1].irq;
  assign fdcEn     = fdcMap.en;
  assign fdcBase   = fdcMap.base;
  assign fdcIrq    = fdcMap.irq;
  assign ideEn     = ideMapQ.en;
  assign ideBase   = ideMapQ.base;
  assign ideIrq    = ideMapQ.irq;

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        wrEn,
  input logic [7:0]  wrData,
  input logic [7:0]  rdData,
  input logic [7:0]  curIdx,
  input logic [15:0] parBase,
  input logic [3:0]  parIrq,
  input logic [15:0] uart0Base,
  input logic [3:0]  uart0Irq,
  input logic [15:0] uart1Base,
  input logic [3:0]  uart1Irq,
  input logic [15:0] fdcBase,
  input logic [15:0] ideBase,
  input logic        reconfig
);

  // R1
  idx_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busSel) |=> (busSel || rdData == $past(wrData)));

  // R3
  bad_idx_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && curIdx >= 8'd3) |-> (rdData == 8'h00));

  // R11
  reconfig_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    reconfig |-> $past(wrEn && busSel, 2));

  // R11
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrEn && busSel) && !$past(wrEn && busSel, 2)) |->
      ($stable(parBase) && $stable(uart0Base) && $stable(uart1Base) &&
       $stable(fdcBase) && $stable(ideBase)));

  // R8
  uart_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uart0Irq == 4'd3 || uart0Irq == 4'd4) && (uart1Irq == 4'd3 || uart1Irq == 4'd4));

  // R7
  par_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((parBase == 16'h0) == (parIrq == 4'd0)) &&
    (parIrq == 4'd0 || parIrq == 4'd5 || parIrq == 4'd7));

endmodule

bind sio_cfg_port sio_cfg_port_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .rdData    (rdData),
  .curIdx    (curIdx),
  .parBase   (parBase),
  .parIrq    (parIrq),
  .uart0Base (uart0Base),
  .uart0Irq  (uart0Irq),
  .uart1Base (uart1Base),
  .uart1Irq  (uart1Irq),
  .fdcBase   (fdcBase),
  .ideBase   (ideBase),
  .reconfig  (reconfig)
);

// File: tb/tb_sio_cfg_port.sv
`timescale 1ns/1ps
module tb_sio_cfg_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  strap = 5'd1;
  logic        busSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData;
  logic        parEn, uart0En, uart1En, fdcEn, ideEn, reconfig;
  logic [15:0] parBase, uart0Base, uart1Base, fdcBase, ideBase, ideAuxBase;
  logic [3:0]  parIrq, uart0Irq, uart1Irq, fdcIrq, ideIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sio_cfg_port dut (
    .clk(clk), .rstN(rstN), .strap(strap), .busSel(busSel), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData),
    .parEn(parEn), .parBase(parBase), .parIrq(parIrq),
    .uart0En(uart0En), .uart0Base(uart0Base), .uart0Irq(uart0Irq),
    .uart1En(uart1En), .uart1Base(uart1Base), .uart1Irq(uart1Irq),
    .fdcEn(fdcEn), .fdcBase(fdcBase), .fdcIrq(fdcIrq),
    .ideEn(ideEn), .ideBase(ideBase), .ideAuxBase(ideAuxBase), .ideIrq(ideIrq),
    .reconfig(reconfig)
  );

  typedef struct packed {
    logic [7:0]  fer, far, ptr;
    logic [4:0]  en;       // {ide, fdc, uart1, uart0, par}
    logic [15:0] parB;  logic [3:0] parI;
    logic [15:0] u0B;   logic [3:0] u0I;
    logic [15:0] u1B;   logic [3:0] u1I;
    logic [15:0] fdcB;  logic [15:0] ideB;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{8'hFF, 8'h00, 8'h00, 5'h1F, 16'h378, 4'd5, 16'h3F8, 4'd4, 16'h3F8, 4'd4, 16'h370, 16'h170},
    '{8'hFF, 8'h00, 8'h08, 5'h1F, 16'h378, 4'd7, 16'h3F8, 4'd4, 16'h3F8, 4'd4, 16'h370, 16'h170},
    '{8'h00, 8'h2A, 8'h00, 5'h00, 16'h278, 4'd5, 16'h3E8, 4'd4, 16'h3E8, 4'd4, 16'h3F0, 16'h1F0},
    '{8'h20, 8'hF7, 8'h00, 5'h00, 16'h000, 4'd0, 16'h2F8, 4'd3, 16'h228, 4'd3, 16'h370, 16'h1F0},
    '{8'h80, 8'h7E, 8'h00, 5'h00, 16'h278, 4'd5, 16'h238, 4'd3, 16'h238, 4'd3, 16'h3F0, 16'h170},
    '{8'h5A, 8'hB9, 8'h00, 5'h1A, 16'h3BC, 4'd7, 16'h2E8, 4'd4, 16'h2E0, 4'd3, 16'h3F0, 16'h1F0},
    '{8'hA0, 8'h68, 8'h08, 5'h00, 16'h378, 4'd7, 16'h338, 4'd4, 16'h338, 4'd4, 16'h370, 16'h170}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [4:0] s);
    @(negedge clk);
    strap = s;
    rstN  = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic portWrite(input logic sel, input logic [7:0] v);
    @(negedge clk);
    busSel = sel; wrData = v; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic portRead(input logic sel, output logic [7:0] v);
    @(negedge clk);
    busSel = sel; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  function automatic logic [4:0] enBits();
    return {ideEn, fdcEn, uart1En, uart0En, parEn};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rv;
    logic [15:0] keepPar;
    int pulses;

    // R6 reset contents, strap 1
    doReset(5'd1);
    chk("R6 strap1 enables", 32'(enBits()), 32'h1F);
    chk("R7 strap1 parBase", 32'(parBase), 32'h3BC);
    chk("R7 strap1 parIrq", 32'(parIrq), 32'd7);
    chk("R8 strap1 uart0Base", 32'(uart0Base), 32'h3F8);
    chk("R8 strap1 uart1Base", 32'(uart1Base), 32'h2F8);
    chk("R9 strap1 fdc", {fdcBase, 12'd0, fdcIrq}, {16'h3F0, 12'd0, 4'd6});
    chk("R10 strap1 ide aux", 32'(ideAuxBase), 32'h3F6);
    chk("R10 strap1 ide irq", 32'(ideIrq), 32'd14);
    chk("R11 no pulse after reset", 32'(reconfig), 32'd0);
    portRead(1'b1, rv); chk("R6 strap1 data idx0", 32'(rv), 32'h4F);

    // R4 identification pair
    doReset(5'd1);
    portRead(1'b0, rv); chk("R4 first id read", 32'(rv), 32'h88);
    portRead(1'b0, rv); chk("R4 second id read", 32'(rv), 32'h00);
    portRead(1'b0, rv); chk("R4 third read index", 32'(rv), 32'h00);
    portWrite(1'b0, 8'h02);
    portRead(1'b0, rv); chk("R1 index readback", 32'(rv), 32'h02);

    // R5 index write ends id sequence
    doReset(5'd1);
    portRead(1'b0, rv); chk("R5 first id read", 32'(rv), 32'h88);
    portWrite(1'b0, 8'h01);
    portRead(1'b0, rv); chk("R5 index after write", 32'(rv), 32'h01);
    portRead(1'b1, rv); chk("R6 strap1 address reg", 32'(rv), 32'h11);

    // R6 other straps
    doReset(5'd31);
    portRead(1'b1, rv); chk("R6 strap31 enable", 32'(rv), 32'h00);
    portWrite(1'b0, 8'h01);
    portRead(1'b1, rv); chk("R6 strap31 address", 32'(rv), 32'h10);
    portWrite(1'b0, 8'h02);
    portRead(1'b1, rv); chk("R6 strap31 power", 32'(rv), 32'h02);
    doReset(5'd6);
    portRead(1'b1, rv); chk("R6 strap6 enable", 32'(rv), 32'h4B);
    chk("R6 strap6 enables decoded", 32'(enBits()), 32'h1B);
    chk("R7 strap6 parBase", {parBase, 12'd0, parIrq}, {16'h378, 12'd0, 4'd5});

    // R7 R8 R9 R10 R2 vector table
    doReset(5'd1);
    for (int i = 0; i < NVEC; i++) begin
      portWrite(1'b0, 8'h00); portWrite(1'b1, VECS[i].fer);
      portWrite(1'b0, 8'h01); portWrite(1'b1, VECS[i].far);
      portWrite(1'b0, 8'h02); portWrite(1'b1, VECS[i].ptr);
      @(negedge clk);
      chk("R7 R8 R9 R10 enables", 32'(enBits()), 32'(VECS[i].en));
      chk("R7 parBase", 32'(parBase), 32'(VECS[i].parB));
      chk("R7 parIrq", 32'(parIrq), 32'(VECS[i].parI));
      chk("R8 uart0Base", 32'(uart0Base), 32'(VECS[i].u0B));
      chk("R8 uart0Irq", 32'(uart0Irq), 32'(VECS[i].u0I));
      chk("R8 uart1Base", 32'(uart1Base), 32'(VECS[i].u1B));
      chk("R8 uart1Irq", 32'(uart1Irq), 32'(VECS[i].u1I));
      chk("R9 fdcBase", 32'(fdcBase), 32'(VECS[i].fdcB));
      chk("R10 ideBase", 32'(ideBase), 32'(VECS[i].ideB));
      chk("R10 ideAuxBase", 32'(ideAuxBase), 32'(VECS[i].ideB) + 32'h206);
      portRead(1'b1, rv); chk("R2 power readback", 32'(rv), 32'(VECS[i].ptr));
    end

    // R3 out-of-range index
    doReset(5'd1);
    keepPar = parBase;
    portWrite(1'b0, 8'h05);
    portWrite(1'b1, 8'hAA);
    pulses = 0;
    for (int k = 0; k < 3; k++) begin
      if (reconfig) pulses++;
      @(negedge clk);
    end
    chk("R3 no pulse on dropped write", 32'(pulses), 32'd0);
    chk("R3 outputs unchanged", 32'(parBase), 32'(keepPar));
    portRead(1'b1, rv); chk("R3 data read index 5", 32'(rv), 32'h00);
    portRead(1'b0, rv); chk("R3 index holds 5", 32'(rv), 32'h05);
    for (int r = 0; r < 3; r++) begin
      portWrite(1'b0, 8'(r));
      portRead(1'b1, rv);
      chk("R3 register untouched", 32'(rv), (r == 0) ? 32'h4F : ((r == 1) ? 32'h11 : 32'h00));
    end

    // R11 timing and pulse
    portWrite(1'b0, 8'h01);
    portWrite(1'b1, 8'h11);
    pulses = 0;
    for (int k = 0; k < 3; k++) begin
      if (reconfig) pulses++;
      @(negedge clk);
    end
    chk("R11 same value no pulse", 32'(pulses), 32'd0);
    portWrite(1'b1, 8'h12);
    chk("R11 pulse not yet", 32'(reconfig), 32'd0);
    chk("R11 decode not yet", 32'(parBase), 32'h3BC);
    @(negedge clk);
    chk("R11 pulse high", 32'(reconfig), 32'd1);
    chk("R11 decode updated", 32'(parBase), 32'h278);
    @(negedge clk);
    chk("R11 pulse one cycle", 32'(reconfig), 32'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule